// File: doc/BRIEF.md
# EFM Clock-Recovery Phase Detector

This block is the digital half of a clock-recovery loop for an EFM-coded data stream. It runs on the VCO clock, divides it by an even ratio (four by default) into a recovered bit clock `bclk` with equal high and low times, and compares each transition of the incoming EFM signal with the rising edges of that clock. A 17.3 MHz VCO gives a nominal 4.32 MHz recovered clock.

The comparison drives two charge-pump controls. The "raise frequency" control `up_n` is active low. The "lower frequency" control `dn` is active high. Each control has its own drive enable (`up_oe`, `dn_oe`), which stands in for a three-state pin: while its enable is low, the control is undriven. In lock both pulses last half a recovered-clock period, so they cancel. When the recovered clock is late, the up pulse is longer. When it is early, the down pulse is longer. Recovered-clock edges that have no EFM transition next to them produce no pulse at all.

Pulling `hold_n` low releases both controls at once and discards any correction in progress, so the loop filter keeps its charge and the VCO frequency stays where it is. The analog VCO, the loop filter and the summing network are outside this block.

Top module: `efm_phase_det`

## Requirements
- R1: `bclk` is the VCO clock divided by DIV_RATIO (default 4). It is high for DIV_RATIO/2 cycles and low for DIV_RATIO/2 cycles. After reset it starts low, counting from the first cycle in which `rst` is low, and it rises after DIV_RATIO/2 cycles.
- R2: While `rst` is high at a clock edge, `up_oe`, `dn_oe` and `bclk` are low after that edge. Reset is synchronous and active high.
- R3: A transition of `efm_in` in either direction is detected at the second rising VCO edge after it is applied (this is the detection edge). Its phase p is the number of VCO edges from the last edge at which `bclk` rose to the detection edge, taken modulo DIV_RATIO. Pulses begin in the cycle after the detection edge.
- R4: Aligned (p = 0): `up_oe` and `dn_oe` both rise in the cycle after the detection edge. Each stays high for DIV_RATIO/2 cycles.
- R5: Recovered clock early (0 < p < DIV_RATIO/2): both enables rise in the cycle after the detection edge. `up_oe` lasts DIV_RATIO/2 cycles and `dn_oe` lasts p + DIV_RATIO/2 cycles.
- R6: Recovered clock late (p >= DIV_RATIO/2, w = DIV_RATIO - p): `up_oe` rises in the cycle after the detection edge and lasts w + DIV_RATIO/2 cycles. `dn_oe` rises w cycles later, in the cycle after `bclk` rises, lasts DIV_RATIO/2 cycles, and ends together with `up_oe`.
- R7: `up_n` is 0 exactly while `up_oe` is 1 and is 1 otherwise. `dn` is 1 exactly while `dn_oe` is 1 and is 0 otherwise.
- R8: While `hold_n` is 0, `up_oe` and `dn_oe` are 0 in the same cycle. A pulse in progress is cancelled and does not resume when `hold_n` returns to 1. EFM transitions detected during hold produce no pulse.
- R9: Without an EFM transition, no pulse starts, whatever `bclk` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock, sampling clock of the whole block |
| rst | input | 1 | Synchronous active-high reset |
| efm_in | input | 1 | Asynchronous EFM data signal |
| hold_n | input | 1 | Active-low hold; low releases both charge-pump controls |
| bclk | output | 1 | Recovered bit clock, VCO clock divided by DIV_RATIO |
| up_n | output | 1 | Active-low frequency-raise control |
| up_oe | output | 1 | Drive enable of `up_n` |
| dn | output | 1 | Active-high frequency-lower control |
| dn_oe | output | 1 | Drive enable of `dn` |

## Verification
Directed scenarios place an EFM transition at every phase offset within one recovered-clock period, alternating rising and falling transitions. This separates the aligned case from the early case and from the late case at both the nearest and the farthest offset. Each case is judged by start cycle, length and polarity of both pulses, so a swapped direction, an off-by-one in the window or a late `dn` start shows up. Separate runs keep the EFM input quiet to show that recovered-clock edges alone pump nothing, assert hold before and during a pulse, and sample `bclk` from reset to confirm its ratio and its starting level.

// File: rtl/efm_pd_pkg.sv
package efm_pd_pkg;

    // Width of all cycle-count fields; limits DIV_RATIO to below 2**SPAN_W / 2.
    localparam int SPAN_W = 8;

    typedef logic [SPAN_W-1:0] span_t;

    // Position of an EFM transition relative to the recovered-clock rising edge.
    typedef enum logic [1:0] {
        PH_ALIGN = 2'd0,
        PH_EARLY = 2'd1,   // recovered clock ahead of data
        PH_LATE  = 2'd2    // recovered clock behind data
    } phase_kind_e;

    // One correction pulse: counter start value and the span in which it drives.
    typedef struct packed {
        span_t total;
        span_t active;
    } pulse_cmd_t;

    typedef struct packed {
        pulse_cmd_t up;
        pulse_cmd_t dn;
    } pulse_pair_t;

    function automatic phase_kind_e classify_phase(input span_t phase, input span_t half);
        if (phase == '0)
            return PH_ALIGN;
        else if (phase < half)
            return PH_EARLY;
        else
            return PH_LATE;
    endfunction

    // Pulse shapes for both controls, given the phase class.
    function automatic pulse_pair_t shape_pulses(input phase_kind_e kind, input span_t phase,
                                                 input span_t half, input span_t div);
        pulse_pair_t r;
        span_t       wait_c;
        wait_c = div - phase;
        unique case (kind)
            PH_EARLY: begin
                r.up.total  = half;
                r.up.active = half;
                r.dn.total  = phase + half;
                r.dn.active = phase + half;
            end
            PH_LATE: begin
                r.up.total  = wait_c + half;
                r.up.active = wait_c + half;
                r.dn.total  = wait_c + half;
                r.dn.active = half;
            end
            default: begin
                r.up.total  = half;
                r.up.active = half;
                r.dn.total  = half;
                r.dn.active = half;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/efm_clk_div.sv
module efm_clk_div
    import efm_pd_pkg::*;
#(
    parameter int DIV_RATIO = 4
) (
    input  logic  clk,
    input  logic  rst,
    output logic  bclk,
    output span_t phase
);
    localparam int    CNT_W  = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int    HALF   = DIV_RATIO / 2;
    localparam span_t HALF_S = span_t'(HALF);

    logic [CNT_W-1:0] cnt_q;
    span_t            cnt_w;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == CNT_W'(DIV_RATIO - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        cnt_w = span_t'(cnt_q);
        bclk  = (cnt_w >= HALF_S);
        // cycles since bclk rose, modulo DIV_RATIO
        phase = (cnt_w >= HALF_S) ? (cnt_w - HALF_S) : (cnt_w + HALF_S);
    end

endmodule

// File: rtl/efm_edge_sync.sv
module efm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_evt
);
    // STAGES synchroniser flops plus one history flop for the edge compare
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign edge_evt = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/efm_pulse_shaper.sv
module efm_pulse_shaper
    import efm_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  pulse_cmd_t cmd,
    output logic       on
);
    span_t remain_q;
    span_t act_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remain_q <= '0;
            act_q    <= '0;
        end else if (load) begin
            remain_q <= cmd.total;
            act_q    <= cmd.active;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // drives during the last act_q cycles of the count
    assign on = (remain_q != '0) && (remain_q <= act_q);

endmodule

// File: rtl/efm_phase_det.sv
module efm_phase_det
    import efm_pd_pkg::*;
#(
    parameter int DIV_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic efm_in,
    input  logic hold_n,
    output logic bclk,
    output logic up_n,
    output logic up_oe,
    output logic dn,
    output logic dn_oe
);
    localparam span_t HALF_S  = span_t'(DIV_RATIO / 2);
    localparam span_t DIV_S   = span_t'(DIV_RATIO);
    localparam int    N_PUMPS = 2;   // index 0: up, index 1: down

    span_t       phase;
    logic        efm_evt;
    phase_kind_e kind;
    pulse_pair_t pair;
    pulse_cmd_t  cmd  [N_PUMPS];
    logic        pump [N_PUMPS];
    logic        load;

    efm_clk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst   (rst),
        .bclk  (bclk),
        .phase (phase)
    );

    efm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (efm_in),
        .edge_evt (efm_evt)
    );

    always_comb begin
        kind   = classify_phase(phase, HALF_S);
        pair   = shape_pulses(kind, phase, HALF_S, DIV_S);
        cmd[0] = pair.up;
        cmd[1] = pair.dn;
        load   = efm_evt && hold_n;
    end

    for (genvar g = 0; g < N_PUMPS; g++) begin : g_pump
        efm_pulse_shaper u_shaper (
            .clk  (clk),
            .rst  (rst),
            .clr  (!hold_n),
            .load (load),
            .cmd  (cmd[g]),
            .on   (pump[g])
        );
    end

    always_comb begin
        up_oe = hold_n && pump[0];
        dn_oe = hold_n && pump[1];
        up_n  = !up_oe;
        dn    = dn_oe;
    end

endmodule

// File: rtl/efm_phase_det_chk.sv
module efm_phase_det_chk #(
    parameter int HALF = 2
) (
    input logic clk,
    input logic rst,
    input logic hold_n,
    input logic bclk,
    input logic up_n,
    input logic up_oe,
    input logic dn,
    input logic dn_oe,
    input logic efm_evt
);
    logic       bclk_q;
    logic [7:0] run_q;

    // cycles bclk has kept its level, for the ratio window
    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            run_q  <= '0;
        end else begin
            bclk_q <= bclk;
            if (bclk != bclk_q)
                run_q <= '0;
            else if (run_q != 8'hFF)
                run_q <= run_q + 1'b1;
        end
    end

    assert_bclk_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        (bclk != bclk_q) |-> (run_q >= 8'(HALF - 1) && run_q <= 8'(HALF)));

    assert_bclk_level_R1: assert property (@(posedge clk) disable iff (rst)
        run_q <= 8'(HALF));

    assert_up_polarity_R7: assert property (@(posedge clk) disable iff (rst)
        up_oe ? !up_n : up_n);

    assert_dn_polarity_R7: assert property (@(posedge clk) disable iff (rst)
        dn_oe ? dn : !dn);

    assert_hold_release_R8: assert property (@(posedge clk) disable iff (rst)
        !hold_n |-> (!up_oe && !dn_oe));

    assert_start_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(up_oe) |-> $past(efm_evt));

    assert_dn_inside_up_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_oe) |-> up_oe);

endmodule

bind efm_phase_det efm_phase_det_chk #(.HALF(DIV_RATIO / 2)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (hold_n),
    .bclk    (bclk),
    .up_n    (up_n),
    .up_oe   (up_oe),
    .dn      (dn),
    .dn_oe   (dn_oe),
    .efm_evt (efm_evt)
);

// File: tb/sim_efm_phase_det.sv
`timescale 1ns/1ps
module sim_efm_phase_det;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic efm_in = 1'b0;
    logic hold_n = 1'b1;
    logic bclk, up_n, up_oe, dn, dn_oe;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    efm_phase_det #(.DIV_RATIO(DIV), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .efm_in(efm_in), .hold_n(hold_n),
        .bclk(bclk), .up_n(up_n), .up_oe(up_oe), .dn(dn), .dn_oe(dn_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns at the negedge that follows the edge at which bclk rose
    task automatic sync_rise();
        logic pv;
        @(negedge clk);
        pv = bclk;
        forever begin
            @(negedge clk);
            if (bclk && !pv) break;
            pv = bclk;
        end
    endtask

    // R2 then R1: reset state and divided clock from reset release
    task automatic t_reset_and_clock();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!up_oe, "R2 up_oe in reset", up_oe, 0);
        check(!dn_oe, "R2 dn_oe in reset", dn_oe, 0);
        check(!bclk,  "R2 bclk in reset",  bclk,  0);
        rst = 1'b0;
        for (int k = 0; k < 3 * DIV; k++) begin
            check(bclk == ((k % DIV) >= HALF), "R1 bclk level", bclk, int'((k % DIV) >= HALF));
            @(negedge clk);
        end
    endtask

    // R3..R7: one EFM transition detected o edges after a bclk rise
    task automatic t_phase(input int o);
        int p, w, eus, eul, eds, edl;
        int us = -1, ul = 0, ds = -1, dl = 0, bad = 0;
        string tag;
        p = o % DIV;
        w = DIV - p;
        if (p == 0) begin
            tag = "R3 R4 aligned"; eus = 0; eul = HALF; eds = 0; edl = HALF;
        end else if (p < HALF) begin
            tag = "R3 R5 early";   eus = 0; eul = HALF; eds = 0; edl = p + HALF;
        end else begin
            tag = "R3 R6 late";    eus = 0; eul = w + HALF; eds = w; edl = HALF;
        end
        sync_rise();
        repeat (o - 2) @(negedge clk);
        efm_in = ~efm_in;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3 * DIV; i++) begin
            if (up_oe) begin
                if (us < 0) us = i;
                ul++;
                if (up_n !== 1'b0) bad++;
            end else if (up_n !== 1'b1) bad++;
            if (dn_oe) begin
                if (ds < 0) ds = i;
                dl++;
                if (dn !== 1'b1) bad++;
            end else if (dn !== 1'b0) bad++;
            @(negedge clk);
        end
        check(us == eus, {tag, " up start"}, us, eus);
        check(ul == eul, {tag, " up length"}, ul, eul);
        check(ds == eds, {tag, " dn start"}, ds, eds);
        check(dl == edl, {tag, " dn length"}, dl, edl);
        check(bad == 0, "R7 pulse polarity", bad, 0);
    endtask

    // R9: recovered-clock edges alone start nothing
    task automatic t_idle();
        int seen = 0;
        for (int i = 0; i < 5 * DIV; i++) begin
            if (up_oe || dn_oe) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R9 idle no pulse", seen, 0);
    endtask

    // R8: transitions during hold are ignored; hold cancels a running pulse
    task automatic t_hold();
        int seen = 0;
        hold_n = 1'b0;
        #1;
        check(!up_oe && !dn_oe, "R8 hold enables", int'(up_oe || dn_oe), 0);
        efm_in = ~efm_in;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (up_oe || dn_oe) seen++;
        end
        hold_n = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (up_oe || dn_oe) seen++;
        end
        check(seen == 0, "R8 edge during hold", seen, 0);

        seen = 0;
        sync_rise();
        efm_in = ~efm_in;            // late case, up pulse of DIV cycles
        repeat (3) @(negedge clk);
        check(up_oe == 1'b1, "R6 pulse before hold", up_oe, 1);
        hold_n = 1'b0;
        #1;
        check(!up_oe && !dn_oe, "R8 hold mid pulse", int'(up_oe || dn_oe), 0);
        repeat (2) @(negedge clk);
        hold_n = 1'b1;
        for (int i = 0; i < 3 * DIV; i++) begin
            #1;
            if (up_oe || dn_oe) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R8 no resume after hold", seen, 0);
    endtask

    initial begin
        t_reset_and_clock();
        t_idle();
        for (int o = 2; o <= DIV + 1; o++) t_phase(o);
        for (int o = DIV + 1; o >= 2; o--) t_phase(o);
        t_hold();
        t_phase(2 + HALF);
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule